// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block is a synthesizable SPI slave that answers like a small byte-wide serial EEPROM. Its storage is an on-chip register array of `2**ADDR_W` bytes, and every location starts at the erased value after reset. The interface uses SPI mode 0, in which SCK idles low. The slave samples SI on the rising edge of SCK and changes SO after the falling edge, and each byte moves most significant bit first. The three SPI inputs are asynchronous to the system clock and pass through a synchronizer.

The block accepts four commands. Read (0x03) streams bytes from a counter that runs through the whole memory. Write (0x02) fills a page buffer. Write-enable (0x06) sets a latch that a write needs. Read-status (0x05) returns a byte that holds the write-in-progress flag and the latch. A write only collects bytes while chip select is low. The self-timed programming cycle starts when chip select rises. It lasts `PROG_CYCLES` system clocks however many bytes were buffered, and only then do the buffered bytes reach the array. The default gives 1 KiB of storage. Setting `ADDR_W` to 13 gives the 8K x 8 organisation.

SO carries meaning only while `so_oe` is high. A pad-level tri-state buffer turns that pair into a high-impedance pin.

Top module: `spi_ee_slave`

## Requirements
- R1: The command byte is the first byte after chip select falls. 0x03 is read, 0x02 is write, 0x06 sets the write-enable latch and 0x05 reads status. Any other code is ignored for the rest of the selection, and `so_oe` stays low.
- R2: Read and write send a two-byte address after the command, high byte first. Only the low `ADDR_W` address bits are used, and the upper bits are ignored.
- R3: Each data byte of a read returns the location at the read counter, and the counter then increments. The counter wraps from `2**ADDR_W-1` to 0, and reads have no page limit.
- R4: Write data bytes land in a 32-entry page buffer at the low 5 address bits. The index wraps from 31 to 0 inside the same page. Programming changes only the locations that received a byte, and every other location in the page keeps its value.
- R5: Programming starts on the chip-select rise that ends a write with at least one complete data byte. It lasts `PROG_CYCLES` clocks whether 1 or 32 bytes were buffered, and the array changes only at its end.
- R6: The status byte has bit 0 = write in progress and bit 1 = write-enable latch, and all other bits are 0. It is sent on SO during the byte after the 0x05 command and again for every further byte.
- R7: A write command is ignored in full while the write-enable latch is clear, and no programming cycle starts. The latch clears when a programming cycle ends.
- R8: While a write is in progress, read, write and write-enable commands are ignored. Only read-status is honoured.
- R9: SI is sampled on the rising SCK edge, SO changes after the falling SCK edge, and data moves MSb first.
- R10: `so_oe` is high only while chip select is low and a read or status response is being shifted out.
- R11: After a synchronous active-low reset, all storage holds 0xFF, the status byte reads 0x00 and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idles low |
| si | input | 1 | SPI serial data into the slave |
| so | output | 1 | SPI serial data out of the slave |
| so_oe | output | 1 | High while `so` is to be driven onto the bus |

## Verification
On every cycle, the embedded assertions check four things:
- The output enable falls silent once chip select is high.
- Busy only rises after a programming start.
- A programming start never happens without the latch, and the latch is clear once busy falls.
- The read counter steps by one per streamed byte, and no read or write session is open while busy.

Only the bench's scenarios can show the rest. It compares the stored data against a behavioural memory model: masked high address bits, wrap inside a page, wrap at the top of memory, and untouched neighbours in a partly written page. The same scenarios show that commands arriving during programming or without the latch leave no trace, and that the status byte reports the right flags at each point.

// File: rtl/spi_ee_pkg.sv
// Package: command codes and session states shared by the serial EEPROM slave.
// Assumes: byte-wide SPI commands, one session per chip-select low period.
package spi_ee_pkg;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_RDSR  = 8'h05;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_AHI,
        ST_ALO,
        ST_READ,
        ST_WRITE,
        ST_STAT,
        ST_SKIP
    } sess_t;
endpackage

// File: rtl/spi_ee_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independently slow compared with clk (SPI rates well below clk).
module spi_ee_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_rest
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_ee_link.sv
// Module: SPI mode-0 bit engine. Assembles received bytes on SCK rises and
// shifts response bytes out on SCK falls, MSb first.
// Assumes: inputs already synchronized to clk; tx_load never coincides with a falling edge.
module spi_ee_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       si_s,
    input  logic [7:0] tx_byte,
    input  logic       tx_load,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       cs_rise,
    output logic       so,
    output logic       so_oe
);
    logic       sck_d, cs_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_hold;
    logic       tx_pend;
    logic [6:0] tx_sh;
    logic       sck_rise, sck_fall;

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign rx_valid = sck_rise && !cs_n_s && (bit_cnt == 3'd7);
    assign rx_byte  = {rx_sh, si_s};

    // Delay registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Receive shifter and bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            rx_sh   <= {rx_sh[5:0], si_s};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Transmit path: a loaded byte starts on the falling edge that opens the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_pend <= 1'b0;
            tx_sh   <= '0;
            so      <= 1'b0;
            so_oe   <= 1'b0;
        end else if (cs_n_s) begin
            tx_pend <= 1'b0;
            so      <= 1'b0;
            so_oe   <= 1'b0;
        end else begin
            if (sck_fall) begin
                if (bit_cnt == 3'd0) begin
                    if (tx_pend) begin
                        so      <= tx_hold[7];
                        tx_sh   <= tx_hold[6:0];
                        so_oe   <= 1'b1;
                        tx_pend <= 1'b0;
                    end else begin
                        so    <= 1'b0;
                        so_oe <= 1'b0;
                    end
                end else begin
                    so    <= tx_sh[6];
                    tx_sh <= {tx_sh[5:0], 1'b0};
                end
            end
            if (tx_load) begin
                tx_hold <= tx_byte;
                tx_pend <= 1'b1;
            end
        end
    end

    assert_quiet_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !so_oe);
endmodule

// File: rtl/spi_ee_store.sv
// Module: byte storage, 32-entry page buffer with per-entry valid flags, and
// the self-timed programming timer that commits buffered bytes at its end.
// Assumes: buffer is filled only while idle; start is given only while idle.
module spi_ee_store #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5,
    parameter int PROG_CYCLES = 250000,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     prog_start,
    input  logic [ADDR_W-PAGE_W-1:0] prog_page,
    output logic                     busy,
    output logic                     done
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    pvalid;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]         cnt;

    assign rd_data = mem[rd_addr];
    assign done    = busy && (cnt == '0);

    // Programming timer: fixed length regardless of how many bytes are buffered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (prog_start && !busy) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(PROG_CYCLES - 1);
            page_q <= prog_page;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Page buffer fill and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
        end else if (buf_clr) begin
            pvalid <= '0;
        end else if (buf_we) begin
            pbuf[buf_idx]   <= buf_data;
            pvalid[buf_idx] <= 1'b1;
        end
    end

    // Array: erased at reset, valid buffer entries committed when the timer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (done) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pvalid[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
        end
    end

    assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_start));
    assert_no_fill_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we || buf_clr) |-> !busy);
endmodule

// File: rtl/spi_ee_slave.sv
// Module: top of the serial EEPROM slave. Decodes the command byte, collects
// the address, runs read streaming, status replies and page-buffer writes.
// Assumes: SPI mode 0, SCK at most about clk/8, 9 <= ADDR_W <= 16.
module spi_ee_slave
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5,
    parameter int PROG_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int HI_W = ADDR_W - 8;

    logic                     cs_n_s, sck_s, si_s;
    logic [7:0]               rx_byte, tx_byte, rd_data, status;
    logic                     rx_valid, cs_rise, tx_load;
    logic                     buf_clr, buf_we, prog_start, busy, done;
    sess_t                    state;
    logic                     is_wr, wel, wr_armed;
    logic [HI_W-1:0]          hi_q;
    logic [ADDR_W-1:0]        rd_ptr, new_addr, rd_addr;
    logic [PAGE_W-1:0]        wr_idx;
    logic [ADDR_W-PAGE_W-1:0] wr_page;

    spi_ee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q({cs_n_s, sck_s, si_s})
    );

    spi_ee_link i_link (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .si_s(si_s),
        .tx_byte(tx_byte), .tx_load(tx_load), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .cs_rise(cs_rise), .so(so), .so_oe(so_oe)
    );

    spi_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) i_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(wr_idx), .buf_data(rx_byte),
        .prog_start(prog_start), .prog_page(wr_page), .busy(busy), .done(done)
    );

    // Response and buffer controls derived from the current session state.
    always_comb begin
        status     = {6'b0, wel, busy};
        new_addr   = {hi_q, rx_byte};
        rd_addr    = (state == ST_ALO) ? new_addr : rd_ptr;
        tx_load    = rx_valid && (((state == ST_CMD) && (rx_byte == CMD_RDSR)) ||
                                  (state == ST_STAT) || (state == ST_READ) ||
                                  ((state == ST_ALO) && !is_wr && !busy));
        tx_byte    = ((state == ST_CMD) || (state == ST_STAT)) ? status : rd_data;
        buf_clr    = rx_valid && (state == ST_ALO) && is_wr;
        buf_we     = rx_valid && (state == ST_WRITE);
        prog_start = cs_rise && wr_armed && !busy;
    end

    // Session sequencer, restarted whenever chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            is_wr    <= 1'b0;
            hi_q     <= '0;
            rd_ptr   <= '0;
            wr_idx   <= '0;
            wr_page  <= '0;
            wr_armed <= 1'b0;
        end else if (cs_n_s) begin
            state    <= ST_CMD;
            wr_armed <= 1'b0;
        end else if (rx_valid) begin
            case (state)
                ST_CMD: begin
                    if (rx_byte == CMD_RDSR)                  state <= ST_STAT;
                    else if (busy)                            state <= ST_SKIP;
                    else if (rx_byte == CMD_READ) begin       state <= ST_AHI; is_wr <= 1'b0; end
                    else if (rx_byte == CMD_WRITE && wel) begin state <= ST_AHI; is_wr <= 1'b1; end
                    else                                      state <= ST_SKIP;
                end
                ST_AHI: begin
                    hi_q  <= rx_byte[HI_W-1:0];
                    state <= ST_ALO;
                end
                ST_ALO: begin
                    if (is_wr) begin
                        wr_page <= new_addr[ADDR_W-1:PAGE_W];
                        wr_idx  <= new_addr[PAGE_W-1:0];
                        state   <= ST_WRITE;
                    end else begin
                        rd_ptr <= new_addr + 1'b1;
                        state  <= ST_READ;
                    end
                end
                ST_READ:  rd_ptr <= rd_ptr + 1'b1;
                ST_WRITE: begin
                    wr_idx   <= wr_idx + 1'b1;
                    wr_armed <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Write-enable latch: set by its command while idle, cleared when programming ends.
    always_ff @(posedge clk) begin
        if (!rst_n)  wel <= 1'b0;
        else if (done) wel <= 1'b0;
        else if (rx_valid && (state == ST_CMD) && (rx_byte == CMD_WREN) && !busy) wel <= 1'b1;
    end

    assert_prog_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wel);
    assert_latch_cleared_after_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    assert_read_ptr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (state == ST_READ)) |=> (rd_ptr == $past(rd_ptr) + 1'b1));
    assert_no_access_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((state != ST_READ) && (state != ST_WRITE) && (state != ST_AHI)));
endmodule

// File: tb/test_spi_ee_slave.sv
// Bench: drives SPI mode-0 sessions and compares replies against a behavioural
// memory model; a per-clock monitor checks the output enable while deselected.
module test_spi_ee_slave;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam int PROG = 2000;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    bit oe_seen = 1'b0;
    int desel_cnt = 0;
    bit mon_on = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    bit ref_wel = 1'b0;
    logic [7:0] txq[$], rxq[$], wdata[$];

    always #10 clk = ~clk;

    spi_ee_slave #(.ADDR_W(AW), .PAGE_W(5), .PROG_CYCLES(PROG)) i_spi_ee_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock monitor: R10 output enable silent while deselected.
    always @(negedge clk) begin
        if (so_oe) oe_seen = 1'b1;
        if (mon_on) begin
            if (cs_n) desel_cnt++; else desel_cnt = 0;
            if (desel_cnt > 4) chk("R10 so_oe while deselected", int'(so_oe), 0);
        end
    end

    // One chip-select session: shifts txq out, captures rxq (R9 mode 0, MSb first).
    task automatic spi_txn();
        rxq.delete();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        foreach (txq[k]) begin
            logic [7:0] r;
            for (int b = 7; b >= 0; b--) begin
                si = txq[k][b];
                repeat (HALF) @(negedge clk);
                r[b] = so;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
            rxq.push_back(r);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic rdsr(output logic [7:0] st);
        txq = '{8'h05, 8'h00, 8'h00};
        spi_txn();
        st = rxq[1];
        chk("R6 status repeated", int'(rxq[2]), int'(rxq[1]));
    endtask

    task automatic wren(input bit idle);
        txq = '{8'h06};
        spi_txn();
        if (idle) ref_wel = 1'b1;
    endtask

    // Write session; the model commits with in-page wrap only when accepted.
    task automatic do_write(input int a, input bit idle);
        txq = '{8'h02, 8'(a >> 8), 8'(a)};
        foreach (wdata[k]) txq.push_back(wdata[k]);
        spi_txn();
        if (ref_wel && idle && wdata.size() > 0) begin
            foreach (wdata[k]) begin
                int ma = a & (DEPTH - 1);
                ref_mem[(ma & ~31) | ((ma + k) & 31)] = wdata[k];
            end
            ref_wel = 1'b0;
        end
    endtask

    task automatic do_read(input string tag, input int a, input int n);
        txq = '{8'h03, 8'(a >> 8), 8'(a)};
        for (int k = 0; k < n; k++) txq.push_back(8'h00);
        spi_txn();
        for (int k = 0; k < n; k++)
            chk(tag, int'(rxq[3+k]), int'(ref_mem[(a + k) & (DEPTH - 1)]));
    endtask

    initial begin
        logic [7:0] st;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        mon_on = 1'b1;

        // R11: reset state.
        chk("R11 so_oe after reset", int'(so_oe), 0);
        rdsr(st);
        chk("R11 status after reset", int'(st), 8'h00);
        do_read("R11 erased contents", 0, 3);

        // R6/R7: latch visible in status bit 1.
        wren(1'b1);
        rdsr(st);
        chk("R6 status with latch", int'(st), 8'h02);

        // R2: high address bits ignored (0xFC10 maps to 0x010).
        wdata = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(16'hFC10, 1'b1);
        rdsr(st);
        chk("R5 R6 status while programming", int'(st), 8'h03);

        // R8: read during programming gets no reply; write and latch set ignored.
        oe_seen = 1'b0;
        txq = '{8'h03, 8'h00, 8'h10, 8'h00};
        spi_txn();
        chk("R8 read ignored while busy", int'(oe_seen), 0);
        wren(1'b0);
        wdata = '{8'h77};
        do_write(16'h0011, 1'b0);
        repeat (PROG + 200) @(negedge clk);
        rdsr(st);
        chk("R7 latch cleared after programming", int'(st), 8'h00);
        do_read("R4 R2 R3 written bytes and neighbours", 16'h000E, 6);

        // R7: write without latch is ignored and starts no programming.
        wdata = '{8'h99};
        do_write(16'h0100, 1'b1);
        rdsr(st);
        chk("R7 no programming without latch", int'(st), 8'h00);
        do_read("R7 location unchanged", 16'h0100, 1);

        // R4: index wraps inside the page (start at index 30 of page 1).
        wren(1'b1);
        wdata = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
        do_write(16'h003E, 1'b1);
        repeat (PROG + 200) @(negedge clk);
        do_read("R4 page wrap", 16'h001E, 36);

        // R5: full 32-byte page.
        wren(1'b1);
        wdata.delete();
        for (int k = 0; k < 32; k++) wdata.push_back(8'(8'hC0 + k));
        do_write(16'h0040, 1'b1);
        rdsr(st);
        chk("R5 busy after full page", int'(st), 8'h03);
        repeat (PROG + 200) @(negedge clk);
        do_read("R5 full page committed", 16'h0040, 32);

        // R3: read counter wraps at top of memory.
        wren(1'b1);
        wdata = '{8'h5A};
        do_write(16'h0000, 1'b1);
        repeat (PROG + 200) @(negedge clk);
        wren(1'b1);
        wdata = '{8'hA5};
        do_write(DEPTH - 1, 1'b1);
        repeat (PROG + 200) @(negedge clk);
        do_read("R3 wrap at top", DEPTH - 2, 4);

        // R1: unknown command gives no reply.
        oe_seen = 1'b0;
        txq = '{8'h9F, 8'h00, 8'h00};
        spi_txn();
        chk("R1 unknown command silent", int'(oe_seen), 0);
        rdsr(st);
        chk("R1 status after unknown command", int'(st), 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule